// File: doc/BRIEF.md
# One-Wire Search Triplet Unit

This block carries out a single bit step of the one-wire ROM search. After a start pulse it generates two read slots on the open-drain bus. The first slot returns the addressed bit of every device still in the search. The second slot returns the complement of that bit. From the two results and a preferred-direction input, the unit picks the branch to follow. Unless the bus reports the error pattern, it then writes the chosen bit back with a write slot, so that devices on the other branch drop out.

The result comes back as a 3-bit status word with a fixed layout. Bit 0 is the first read, bit 1 is the second read and bit 2 is the direction taken. A controller around the block steps it once per ROM bit position. That controller keeps the 64-bit path and the discrepancy position across steps. Slot timing is counted in microseconds, derived from the clock by a prescaler parameter.

Top module: `triplet_search`

## Requirements
- R1: After reset, `drive_low`, `busy` and `done` are 0 and `status` is 3'b000. While the unit is idle it never pulls the line low.
- R2: A step reads the first bit, then the complement bit. The status places the first read in bit 0 and the second read in bit 1.
- R3: If both reads return 1, the status is 3'b011, no write slot follows, and `done` rises right after the second read slot.
- R4: If both reads return 0, the direction is the `pref_dir` value captured at start, giving 3'b100 (pref 1) or 3'b000 (pref 0).
- R5: If exactly one read returns 1, the direction equals the first read: 3'b101 when the first read is 1, 3'b010 when the second read is 1.
- R6: Outside the error case, a third slot writes the direction bit. It holds the line low for LONG_LOW_US when writing 0 and for SHORT_LOW_US when writing 1.
- R7: A read slot holds the line low for exactly SHORT_LOW_US and then releases it. The line level is taken SAMPLE_US after the slot begins.
- R8: Each slot lasts SLOT_US. `done` is a single-cycle pulse that arrives within a few clock cycles after the last slot ends.
- R9: From `done` until the next accepted start, `status` holds its value. A start pulse while `busy` is high is ignored and does not alter the step in progress.
- R10: `busy` rises the cycle after an accepted start and falls in the cycle that `done` is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Single-cycle request to run one step; accepted only when idle |
| pref_dir | input | 1 | Branch to take when both reads return 0; captured at start |
| line_in | input | 1 | Sensed level of the one-wire line (asynchronous) |
| drive_low | output | 1 | 1 pulls the open-drain line low |
| busy | output | 1 | A step is in progress |
| done | output | 1 | Single-cycle pulse marking the end of a step |
| status | output | 3 | Bit 0 first read, bit 1 second read, bit 2 direction taken |

## Verification
The assertions assume that `start` is a single pulse and that the environment holds reset for at least one clock edge. They also assume that the line model only ever pulls the line low and never drives it high against the unit. The bench issues start only from idle, except for one deliberate pulse in mid-step. Its device model pulls the line only inside a window around the sample point of a read slot, so the sampled value depends on both the line and the sampling instant. Random response pairs and preferences cover all four read outcomes in both preferences.

// File: rtl/triplet_pkg.sv
package triplet_pkg;

    typedef enum logic [1:0] {
        SLOT_READ = 2'd0,
        SLOT_WR0  = 2'd1,
        SLOT_WR1  = 2'd2
    } slot_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RD_ID  = 2'd1,
        ST_RD_CMP = 2'd2,
        ST_WR_DIR = 2'd3
    } tri_state_t;

    // Layout is fixed: bit 0 first read, bit 1 complement read, bit 2 direction.
    typedef struct packed {
        logic dir;
        logic cmp_bit;
        logic id_bit;
    } tri_status_t;

    function automatic logic is_bus_error(input logic id_bit, input logic cmp_bit);
        return id_bit & cmp_bit;
    endfunction

    function automatic tri_status_t decide(input logic id_bit, input logic cmp_bit,
                                           input logic pref);
        tri_status_t r;
        r.id_bit  = id_bit;
        r.cmp_bit = cmp_bit;
        if (is_bus_error(id_bit, cmp_bit))
            r.dir = 1'b0;
        else if (!id_bit && !cmp_bit)
            r.dir = pref;
        else
            r.dir = id_bit;
        return r;
    endfunction

    function automatic slot_kind_t write_kind(input logic bit_val);
        return bit_val ? SLOT_WR1 : SLOT_WR0;
    endfunction

endpackage

// File: rtl/us_prescaler.sv
module us_prescaler #(
    parameter int CLKS_PER_US = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    output logic tick
);
    localparam int PW = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
    localparam logic [PW-1:0] LAST = PW'(CLKS_PER_US - 1);

    logic [PW-1:0] pre_q;

    assign tick = (pre_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clear)
            pre_q <= '0;
        else if (tick)
            pre_q <= '0;
        else
            pre_q <= pre_q + 1'b1;
    end
endmodule

// File: rtl/slot_gen.sv
module slot_gen
    import triplet_pkg::*;
#(
    parameter int CLKS_PER_US  = 50,
    parameter int SHORT_LOW_US = 6,
    parameter int LONG_LOW_US  = 60,
    parameter int SAMPLE_US    = 15,
    parameter int SLOT_US      = 70
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req,
    input  slot_kind_t kind,
    input  logic       line_in,
    output logic       drive_low,
    output logic       slot_done,
    output logic       sample_bit
);
    localparam int CW = $clog2(SLOT_US + 1);
    localparam logic [CW-1:0] SHORT_C  = CW'(SHORT_LOW_US);
    localparam logic [CW-1:0] LONG_C   = CW'(LONG_LOW_US);
    localparam logic [CW-1:0] SAMPLE_C = CW'(SAMPLE_US - 1);
    localparam logic [CW-1:0] END_C    = CW'(SLOT_US - 1);

    logic          active_q;
    slot_kind_t    kind_q;
    logic [CW-1:0] us_q;
    logic [1:0]    sync_q;
    logic          sample_q;
    logic          tick;
    logic [CW-1:0] low_len;

    us_prescaler #(.CLKS_PER_US(CLKS_PER_US)) u_pre (
        .clk   (clk),
        .rst   (rst),
        .clear (!active_q),
        .tick  (tick)
    );

    assign low_len    = (kind_q == SLOT_WR0) ? LONG_C : SHORT_C;
    assign drive_low  = active_q && (us_q < low_len);
    assign slot_done  = active_q && tick && (us_q == END_C);
    assign sample_bit = sample_q;

    always_ff @(posedge clk) begin
        if (rst)
            sync_q <= 2'b11;
        else
            sync_q <= {sync_q[0], line_in};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            kind_q   <= SLOT_READ;
            us_q     <= '0;
            sample_q <= 1'b0;
        end else if (!active_q) begin
            if (req) begin
                active_q <= 1'b1;
                kind_q   <= kind;
                us_q     <= '0;
            end
        end else if (tick) begin
            if (us_q == SAMPLE_C && kind_q == SLOT_READ)
                sample_q <= sync_q[1];
            if (us_q == END_C) begin
                active_q <= 1'b0;
                us_q     <= '0;
            end else begin
                us_q <= us_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/triplet_ctrl.sv
module triplet_ctrl
    import triplet_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       pref_dir,
    input  logic       slot_done,
    input  logic       sample_bit,
    output logic       slot_req,
    output slot_kind_t slot_kind,
    output logic       busy,
    output logic       done,
    output logic [2:0] status
);
    tri_state_t  state_q;
    logic        pref_q;
    logic        id_q;
    tri_status_t pend_q;
    tri_status_t status_q;
    logic        done_q;
    logic        req_q;
    slot_kind_t  kind_q;
    tri_status_t dec;

    assign dec       = decide(id_q, sample_bit, pref_q);
    assign slot_req  = req_q;
    assign slot_kind = kind_q;
    assign busy      = (state_q != ST_IDLE);
    assign done      = done_q;
    assign status    = status_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            pref_q   <= 1'b0;
            id_q     <= 1'b0;
            pend_q   <= '0;
            status_q <= '0;
            done_q   <= 1'b0;
            req_q    <= 1'b0;
            kind_q   <= SLOT_READ;
        end else begin
            done_q <= 1'b0;
            req_q  <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (start) begin
                    pref_q  <= pref_dir;
                    req_q   <= 1'b1;
                    kind_q  <= SLOT_READ;
                    state_q <= ST_RD_ID;
                end
                ST_RD_ID: if (slot_done) begin
                    id_q    <= sample_bit;
                    req_q   <= 1'b1;
                    kind_q  <= SLOT_READ;
                    state_q <= ST_RD_CMP;
                end
                ST_RD_CMP: if (slot_done) begin
                    if (is_bus_error(id_q, sample_bit)) begin
                        status_q <= dec;
                        done_q   <= 1'b1;
                        state_q  <= ST_IDLE;
                    end else begin
                        pend_q  <= dec;
                        req_q   <= 1'b1;
                        kind_q  <= write_kind(dec.dir);
                        state_q <= ST_WR_DIR;
                    end
                end
                ST_WR_DIR: if (slot_done) begin
                    status_q <= pend_q;
                    done_q   <= 1'b1;
                    state_q  <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/triplet_search.sv
module triplet_search
    import triplet_pkg::*;
#(
    parameter int CLKS_PER_US  = 50,
    parameter int SHORT_LOW_US = 6,
    parameter int LONG_LOW_US  = 60,
    parameter int SAMPLE_US    = 15,
    parameter int SLOT_US      = 70
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       pref_dir,
    input  logic       line_in,
    output logic       drive_low,
    output logic       busy,
    output logic       done,
    output logic [2:0] status
);
    logic       slot_req;
    slot_kind_t slot_kind;
    logic       slot_done;
    logic       sample_bit;

    triplet_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .pref_dir   (pref_dir),
        .slot_done  (slot_done),
        .sample_bit (sample_bit),
        .slot_req   (slot_req),
        .slot_kind  (slot_kind),
        .busy       (busy),
        .done       (done),
        .status     (status)
    );

    slot_gen #(
        .CLKS_PER_US  (CLKS_PER_US),
        .SHORT_LOW_US (SHORT_LOW_US),
        .LONG_LOW_US  (LONG_LOW_US),
        .SAMPLE_US    (SAMPLE_US),
        .SLOT_US      (SLOT_US)
    ) u_slot (
        .clk        (clk),
        .rst        (rst),
        .req        (slot_req),
        .kind       (slot_kind),
        .line_in    (line_in),
        .drive_low  (drive_low),
        .slot_done  (slot_done),
        .sample_bit (sample_bit)
    );
endmodule

// File: rtl/triplet_search_chk.sv
module triplet_search_chk (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic [2:0] status,
    input logic       drive_low
);
    assert_idle_release_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !drive_low);

    assert_error_code_R3: assert property (@(posedge clk) disable iff (rst)
        (done && status[0] && status[1]) |-> !status[2]);

    assert_forced_dir_R5: assert property (@(posedge clk) disable iff (rst)
        (done && (status[0] ^ status[1])) |-> (status[2] == status[0]));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_status_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(status));

    assert_busy_ends_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(busy) && !busy));

    assert_busy_starts_R10: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy);
endmodule

bind triplet_search triplet_search_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .status    (status),
    .drive_low (drive_low)
);

// File: tb/sim_triplet_search.sv
module sim_triplet_search;
    localparam int CPU   = 4;
    localparam int SHORT = 6;
    localparam int LONG  = 60;
    localparam int SAMP  = 15;
    localparam int SLOT  = 70;
    localparam int SLOT_CYC = SLOT * CPU;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       pref_dir = 1'b0;
    logic       line_in;
    logic       drive_low;
    logic       busy;
    logic       done;
    logic [2:0] status;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // device model state
    logic resp_id = 1'b1;
    logic resp_cmp = 1'b1;
    logic dev_pull = 1'b0;
    logic prev_low = 1'b0;
    int   slots_seen = 0;
    int   slot_cyc = 0;
    int   low_cnt [0:3];

    always #10 clk = ~clk;

    assign line_in = ~(drive_low | dev_pull);

    triplet_search #(
        .CLKS_PER_US  (CPU),
        .SHORT_LOW_US (SHORT),
        .LONG_LOW_US  (LONG),
        .SAMPLE_US    (SAMP),
        .SLOT_US      (SLOT)
    ) u0 (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .pref_dir  (pref_dir),
        .line_in   (line_in),
        .drive_low (drive_low),
        .busy      (busy),
        .done      (done),
        .status    (status)
    );

    // Devices answer 0 by pulling low only in a window around the sample point.
    always @(negedge clk) begin
        if (drive_low && !prev_low) begin
            slots_seen <= slots_seen + 1;
            slot_cyc   <= 1;
            if (slots_seen < 4) low_cnt[slots_seen] <= 1;
        end else begin
            slot_cyc <= slot_cyc + 1;
            if (drive_low && slots_seen >= 1 && slots_seen <= 4)
                low_cnt[slots_seen-1] <= low_cnt[slots_seen-1] + 1;
        end
        prev_low <= drive_low;
        if (slots_seen == 1 && slot_cyc >= 10*CPU && slot_cyc < 22*CPU)
            dev_pull <= !resp_id;
        else if (slots_seen == 2 && slot_cyc >= 10*CPU && slot_cyc < 22*CPU)
            dev_pull <= !resp_cmp;
        else
            dev_pull <= 1'b0;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [2:0] expect_status(input logic a, input logic b, input logic p);
        if (a && b)   return 3'b011;
        if (!a && !b) return {p, 2'b00};
        if (a)        return 3'b101;
        return 3'b010;
    endfunction

    task automatic run_step(input logic a, input logic b, input logic p, input bit poke);
        logic [2:0] exp;
        int n, cyc, lo_exp;
        bit seen;
        exp = expect_status(a, b, p);
        n = (a && b) ? 2 : 3;
        resp_id = a; resp_cmp = b;
        @(negedge clk);
        slots_seen = 0;
        for (int i = 0; i < 4; i++) low_cnt[i] = 0;
        start = 1'b1; pref_dir = p;
        @(negedge clk);
        start = 1'b0; pref_dir = ~p;
        check(busy == 1'b1, "R10 busy after start", busy, 1);
        cyc = 1; seen = 0;
        while (!seen && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            if (poke && cyc == SLOT_CYC + 50) begin
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                cyc++;
            end
            if (done) seen = 1;
        end
        check(seen, "R8 done seen", seen, 1);
        check(status == exp, "R2/R4/R5/R3 status", status, exp);
        check(busy == 1'b0, "R10 busy low at done", busy, 0);
        check(slots_seen == n, "R3/R6 slot count", slots_seen, n);
        check(cyc >= n*SLOT_CYC && cyc <= n*SLOT_CYC + 4*n + 6,
              "R8 step duration", cyc, n*SLOT_CYC);
        check(low_cnt[0] == SHORT*CPU, "R7 read slot 1 low", low_cnt[0], SHORT*CPU);
        check(low_cnt[1] == SHORT*CPU, "R7 read slot 2 low", low_cnt[1], SHORT*CPU);
        if (n == 3) begin
            lo_exp = exp[2] ? SHORT*CPU : LONG*CPU;
            check(low_cnt[2] == lo_exp, "R6 write slot low", low_cnt[2], lo_exp);
        end
        @(negedge clk);
        check(done == 1'b0, "R8 done single cycle", done, 0);
        repeat (30) @(negedge clk);
        check(status == exp, "R9 status held", status, exp);
        check(drive_low == 1'b0 && busy == 1'b0, "R1 idle line released", drive_low, 0);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) low_cnt[i] = 0;
        repeat (3) @(negedge clk);
        check(drive_low == 0 && busy == 0 && done == 0, "R1 reset outputs", {drive_low, busy, done}, 0);
        check(status == 3'b000, "R1 reset status", status, 0);
        rst = 1'b0;
        // directed corners: all four read outcomes, both preferences
        run_step(1'b1, 1'b1, 1'b0, 0);  // R3 error
        run_step(1'b1, 1'b1, 1'b1, 0);  // R3 error ignores pref
        run_step(1'b0, 1'b0, 1'b1, 0);  // R4 pref 1
        run_step(1'b0, 1'b0, 1'b0, 0);  // R4 pref 0
        run_step(1'b1, 1'b0, 1'b0, 0);  // R5 id 1
        run_step(1'b0, 1'b1, 1'b1, 0);  // R5 cmp 1
        run_step(1'b0, 1'b0, 1'b1, 1);  // R9 start during busy ignored
        void'($urandom(32'd4711));
        for (int k = 0; k < 20; k++) begin
            logic [2:0] r;
            r = 3'($urandom);
            run_step(r[0], r[1], r[2], 0);
        end
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(64'd200000 * 20);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule